// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block is the digital divider chain of an integer-N frequency synthesizer. It has two independent halves, each running on its own clock. The reference half counts the reference clock and emits one pulse every R clocks; this sets the phase-comparison rate. The feedback half counts the oscillator clock through a dual-modulus prescaler. A main counter and a swallow counter steer the prescaler, so the half emits one pulse every M·N + A oscillator clocks. Both pulse trains go to a phase comparator. The comparator, charge pump, loop filter and oscillator are not part of this block.

Within one feedback cycle, the prescaler divides by M+1 for its first A output pulses. It then divides by M for the remaining N−A pulses of that cycle. Software-facing values are latched only at the end of a division cycle. A division-ratio change therefore never produces a shortened or stretched output period. A feedback setting where the main count does not exceed the swallow count cannot work. Such a setting is flagged and is not adopted.

Top module: `pswal_divider`

## Requirements
- R1: With `mod_sel` = 0 the base modulus M is 64. The feedback pulse then repeats every 64·N + A oscillator clocks, where N is `n_div` and A is `a_swal`.
- R2: With `mod_sel` = 1 the base modulus M is 128. The feedback pulse then repeats every 128·N + A oscillator clocks.
- R3: The reference pulse repeats every R reference clocks, where R is `r_div`, for any R from 8 to 16383.
- R4: Both `fb_pulse` and `ref_pulse` are high for exactly one clock of their own domain per division cycle.
- R5: New values of `n_div`, `a_swal` and `mod_sel` are latched only at the end of a feedback cycle. New values of `r_div` are latched only at the end of a reference cycle. A change made inside a cycle leaves that cycle's length unchanged.
- R6: A feedback setting is illegal when N ≤ A or N < 3. While an illegal setting is applied, `cfg_err` is 1 from the next oscillator clock on, and the last legal setting stays in use.
- R7: An `r_div` value below 8 is ignored, and the last legal R stays in use.
- R8: Synchronous reset drives `fb_pulse`, `ref_pulse` and `cfg_err` to 0. During reset the block loads the applied legal settings, so the first cycle after reset already divides by them.
- R9: Within a feedback cycle, the prescaler count never reaches its current modulus. The prescaler modulus is M+1 only while fewer than A prescaler outputs have occurred in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock, feedback domain |
| ref_clk | input | 1 | Reference clock, reference domain |
| rst | input | 1 | Synchronous reset, active high, held across edges of both clocks |
| r_div | input | 14 | Reference division ratio R |
| n_div | input | 11 | Main counter value N |
| a_swal | input | 7 | Swallow counter value A |
| mod_sel | input | 1 | Prescaler modulus select: 0 gives 64/65, 1 gives 128/129 |
| ref_pulse | output | 1 | One-clock pulse per reference division cycle |
| fb_pulse | output | 1 | One-clock pulse per feedback division cycle |
| cfg_err | output | 1 | Applied feedback setting is illegal |

## Verification
Two events can fall in the same oscillator clock: the wrap of the main counter that ends a cycle, and the latching of a new setting. These are provoked by changing N, A and the modulus select right after a feedback pulse. The interval in progress must keep the old ratio and the next interval must show the new one, each counted edge by edge against M·N + A computed in the bench. A second case places an illegal setting against a cycle end. Here the error flag must rise while both following intervals keep the previous ratio. The reference half is exercised in the same way with R.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

  parameter int R_W = 14;
  parameter int N_W = 11;
  parameter int A_W = 7;

  typedef logic [R_W-1:0] r_val_t;
  typedef logic [N_W-1:0] n_val_t;
  typedef logic [A_W-1:0] a_val_t;

  typedef struct packed {
    n_val_t n;
    a_val_t a;
    logic   sel;
  } fb_cfg_t;

  // legality of a feedback setting: main count at least n_min and above swallow
  function automatic logic fb_legal(fb_cfg_t c, int unsigned n_min);
    logic [31:0] n_ext;
    logic [31:0] a_ext;
    n_ext = 32'(c.n);
    a_ext = 32'(c.a);
    return (n_ext >= n_min) && (n_ext > a_ext);
  endfunction

  // base modulus M of the prescaler for a given select bit
  function automatic int unsigned base_modulus(logic sel, int unsigned m_log2);
    return sel ? (32'd1 << (m_log2 + 1)) : (32'd1 << m_log2);
  endfunction

  // total feedback ratio M*N + A
  function automatic int unsigned fb_ratio(fb_cfg_t c, int unsigned m_log2);
    return base_modulus(c.sel, m_log2) * 32'(c.n) + 32'(c.a);
  endfunction

endpackage

// File: rtl/pswal_ref_div.sv
module pswal_ref_div
  import pswal_pkg::*;
#(
  parameter int R_MIN = 8,
  parameter int R_DEF = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  r_val_t r_in,
  output logic   ref_pulse,
  output logic   wrap,
  output r_val_t r_act
);

  r_val_t cnt;
  logic   r_ok;

  assign r_ok = (32'(r_in) >= R_MIN);
  assign wrap = (cnt == r_act - r_val_t'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ref_pulse <= 1'b0;
      r_act     <= r_ok ? r_in : r_val_t'(R_DEF);
    end else begin
      ref_pulse <= wrap;
      if (wrap) begin
        cnt <= '0;
        if (r_ok) r_act <= r_in;
      end else begin
        cnt <= cnt + r_val_t'(1);
      end
    end
  end

endmodule

// File: rtl/pswal_prescaler.sv
module pswal_prescaler
  import pswal_pkg::*;
#(
  parameter int M_LOG2 = 6,
  localparam int PC_W  = M_LOG2 + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sel,
  input  logic            swallow,
  output logic            pre_tc,
  output logic [PC_W-1:0] pre_cnt,
  output logic [PC_W-1:0] pre_mod
);

  assign pre_mod = PC_W'(base_modulus(sel, M_LOG2)) + PC_W'(swallow);
  assign pre_tc  = (pre_cnt >= pre_mod - PC_W'(1));

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else if (pre_tc) pre_cnt <= '0;
    else pre_cnt <= pre_cnt + PC_W'(1);
  end

endmodule

// File: rtl/pswal_swallow_ctrl.sv
module pswal_swallow_ctrl
  import pswal_pkg::*;
#(
  parameter int N_MIN = 3,
  parameter int N_DEF = 3,
  parameter int A_DEF = 0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    pre_tc,
  input  fb_cfg_t cfg_in,
  output logic    swallow,
  output logic    boundary,
  output logic    fb_pulse,
  output logic    cfg_err,
  output fb_cfg_t cfg_act
);

  localparam fb_cfg_t CFG_DEF = '{n: n_val_t'(N_DEF), a: a_val_t'(A_DEF), sel: 1'b0};

  n_val_t n_cnt;
  logic   in_legal;
  logic   last;

  assign in_legal = fb_legal(cfg_in, N_MIN);
  assign swallow  = (n_cnt < {{(N_W-A_W){1'b0}}, cfg_act.a});
  assign last     = (n_cnt == cfg_act.n - n_val_t'(1));
  assign boundary = pre_tc && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_cnt    <= '0;
      fb_pulse <= 1'b0;
      cfg_err  <= 1'b0;
      cfg_act  <= in_legal ? cfg_in : CFG_DEF;
    end else begin
      fb_pulse <= boundary;
      cfg_err  <= !in_legal;
      if (pre_tc) begin
        if (last) begin
          n_cnt <= '0;
          if (in_legal) cfg_act <= cfg_in;
        end else begin
          n_cnt <= n_cnt + n_val_t'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
  import pswal_pkg::*;
#(
  parameter int M_LOG2 = 6,
  parameter int R_MIN  = 8,
  parameter int N_MIN  = 3,
  localparam int PC_W  = M_LOG2 + 2
) (
  input  logic        osc_clk,
  input  logic        ref_clk,
  input  logic        rst,
  input  logic [13:0] r_div,
  input  logic [10:0] n_div,
  input  logic [6:0]  a_swal,
  input  logic        mod_sel,
  output logic        ref_pulse,
  output logic        fb_pulse,
  output logic        cfg_err
);

  fb_cfg_t         fb_cfg_in;
  fb_cfg_t         fb_cfg;
  logic            fb_swallow;
  logic            fb_boundary;
  logic            pre_tc;
  logic [PC_W-1:0] pre_cnt;
  logic [PC_W-1:0] pre_mod;
  logic            ref_wrap;
  r_val_t          r_act;

  assign fb_cfg_in = '{n: n_div, a: a_swal, sel: mod_sel};

  pswal_ref_div #(.R_MIN(R_MIN), .R_DEF(R_MIN)) u_ref (
    .clk      (ref_clk),
    .rst      (rst),
    .r_in     (r_div),
    .ref_pulse(ref_pulse),
    .wrap     (ref_wrap),
    .r_act    (r_act)
  );

  pswal_prescaler #(.M_LOG2(M_LOG2)) u_pre (
    .clk    (osc_clk),
    .rst    (rst),
    .sel    (fb_cfg.sel),
    .swallow(fb_swallow),
    .pre_tc (pre_tc),
    .pre_cnt(pre_cnt),
    .pre_mod(pre_mod)
  );

  pswal_swallow_ctrl #(.N_MIN(N_MIN), .N_DEF(N_MIN), .A_DEF(0)) u_swc (
    .clk     (osc_clk),
    .rst     (rst),
    .pre_tc  (pre_tc),
    .cfg_in  (fb_cfg_in),
    .swallow (fb_swallow),
    .boundary(fb_boundary),
    .fb_pulse(fb_pulse),
    .cfg_err (cfg_err),
    .cfg_act (fb_cfg)
  );

endmodule

// File: rtl/pswal_divider_chk.sv
module pswal_divider_chk
  import pswal_pkg::*;
#(
  parameter int M_LOG2 = 6,
  localparam int PC_W  = M_LOG2 + 2
) (
  input logic            osc_clk,
  input logic            ref_clk,
  input logic            rst,
  input logic            fb_pulse,
  input logic            ref_pulse,
  input logic            cfg_err,
  input logic            fb_boundary,
  input fb_cfg_t         fb_cfg,
  input logic [PC_W-1:0] pre_cnt,
  input logic [PC_W-1:0] pre_mod,
  input logic            ref_wrap,
  input r_val_t          r_act
);

  AST_FB_ONE_WIDE: assert property (@(posedge osc_clk) disable iff (rst)
    fb_pulse |=> !fb_pulse); // R4
  AST_REF_ONE_WIDE: assert property (@(posedge ref_clk) disable iff (rst)
    ref_pulse |=> !ref_pulse); // R4
  AST_FB_CFG_HOLD: assert property (@(posedge osc_clk) disable iff (rst)
    !fb_boundary |=> $stable(fb_cfg)); // R5
  AST_REF_CFG_HOLD: assert property (@(posedge ref_clk) disable iff (rst)
    !ref_wrap |=> $stable(r_act)); // R5
  AST_ILLEGAL_HELD: assert property (@(posedge osc_clk) disable iff (rst)
    (cfg_err && fb_boundary && !fb_legal('{n: fb_cfg.n, a: fb_cfg.a, sel: fb_cfg.sel}, 0)) |=> 1'b0); // R6
  AST_ACTIVE_LEGAL: assert property (@(posedge osc_clk) disable iff (rst)
    fb_cfg.n > {{(N_W-A_W){1'b0}}, fb_cfg.a}); // R6
  AST_PRE_BELOW_MOD: assert property (@(posedge osc_clk) disable iff (rst)
    pre_cnt < pre_mod); // R9
  AST_BOUNDARY_PULSE: assert property (@(posedge osc_clk) disable iff (rst)
    fb_boundary |=> fb_pulse); // R1

endmodule

bind pswal_divider pswal_divider_chk #(.M_LOG2(M_LOG2)) u_chk (
  .osc_clk    (osc_clk),
  .ref_clk    (ref_clk),
  .rst        (rst),
  .fb_pulse   (fb_pulse),
  .ref_pulse  (ref_pulse),
  .cfg_err    (cfg_err),
  .fb_boundary(fb_boundary),
  .fb_cfg     (fb_cfg),
  .pre_cnt    (pre_cnt),
  .pre_mod    (pre_mod),
  .ref_wrap   (ref_wrap),
  .r_act      (r_act)
);

// File: tb/test_pswal_divider.sv
module test_pswal_divider;

  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 26;

  logic        osc_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] r_div = 14'd10;
  logic [10:0] n_div = 11'd3;
  logic [6:0]  a_swal = 7'd1;
  logic        mod_sel = 1'b0;
  logic        ref_pulse;
  logic        fb_pulse;
  logic        cfg_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) osc_clk = ~osc_clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  pswal_divider i_pswal_divider (
    .osc_clk  (osc_clk),
    .ref_clk  (ref_clk),
    .rst      (rst),
    .r_div    (r_div),
    .n_div    (n_div),
    .a_swal   (a_swal),
    .mod_sel  (mod_sel),
    .ref_pulse(ref_pulse),
    .fb_pulse (fb_pulse),
    .cfg_err  (cfg_err)
  );

  function automatic int expect_fb(logic sel, int n, int a);
    return (sel ? 128 : 64) * n + a;
  endfunction

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wait_fb();
    do @(negedge osc_clk); while (!fb_pulse);
  endtask

  task automatic count_fb(output int c);
    c = 0;
    do begin
      @(negedge osc_clk);
      c++;
    end while (!fb_pulse);
  endtask

  task automatic wait_ref();
    do @(negedge ref_clk); while (!ref_pulse);
  endtask

  task automatic count_ref(output int c);
    c = 0;
    do begin
      @(negedge ref_clk);
      c++;
    end while (!ref_pulse);
  endtask

  task automatic set_fb(int n, int a, logic sel);
    n_div   = 11'(n);
    a_swal  = 7'(a);
    mod_sel = sel;
  endtask

  initial begin
    int c;
    int wide;
    repeat (12) @(negedge osc_clk);
    rst = 1'b0;
    @(negedge osc_clk);
    check("R8 fb_pulse after reset", int'(fb_pulse), 0);
    check("R8 cfg_err after reset", int'(cfg_err), 0);
    check("R8 ref_pulse after reset", int'(ref_pulse), 0);
    wait_fb();
    count_fb(c);
    check("R8 ratio loaded in reset", c, expect_fb(1'b0, 3, 1));

    // R1 / R2 sweep over small N and all legal A, both moduli
    for (int s = 0; s < 2; s++) begin
      for (int n = 3; n <= 5; n++) begin
        for (int a = 0; a < n; a++) begin
          set_fb(n, a, 1'(s));
          wait_fb();
          count_fb(c);
          check(s == 0 ? "R1 ratio 64N+A" : "R2 ratio 128N+A", c, expect_fb(1'(s), n, a));
          if (a == n - 1) begin
            @(negedge osc_clk);
            wide = int'(fb_pulse);
            check("R4 fb pulse one clock", wide, 0);
            wait_fb();
          end
        end
      end
    end

    // largest swallow value
    set_fb(128, 127, 1'b0);
    wait_fb();
    count_fb(c);
    check("R1 A=127", c, expect_fb(1'b0, 128, 127));
    set_fb(129, 127, 1'b1);
    wait_fb();
    count_fb(c);
    check("R2 A=127", c, expect_fb(1'b1, 129, 127));

    // R5: change right after a cycle end, including the modulus select
    set_fb(4, 2, 1'b0);
    wait_fb();
    count_fb(c);
    set_fb(5, 3, 1'b1);
    count_fb(c);
    check("R5 interval in progress keeps old", c, expect_fb(1'b0, 4, 2));
    count_fb(c);
    check("R5 next interval new", c, expect_fb(1'b1, 5, 3));

    // R6: illegal settings held off
    set_fb(3, 1, 1'b0);
    wait_fb();
    count_fb(c);
    set_fb(4, 4, 1'b0);
    count_fb(c);
    check("R6 cfg_err for N=A", int'(cfg_err), 1);
    check("R6 old ratio kept 1", c, expect_fb(1'b0, 3, 1));
    count_fb(c);
    check("R6 old ratio kept 2", c, expect_fb(1'b0, 3, 1));
    set_fb(2, 0, 1'b1);
    count_fb(c);
    check("R6 cfg_err for N<3", int'(cfg_err), 1);
    check("R6 old ratio kept 3", c, expect_fb(1'b0, 3, 1));
    set_fb(6, 5, 1'b0);
    count_fb(c);
    check("R6 cfg_err clears", int'(cfg_err), 0);
    count_fb(c);
    check("R6 legal adopted", c, expect_fb(1'b0, 6, 5));

    // R3 reference sweep
    for (int r = 8; r <= 13; r++) begin
      r_div = 14'(r);
      wait_ref();
      count_ref(c);
      check("R3 ref ratio", c, r);
    end
    @(negedge ref_clk);
    check("R4 ref pulse one clock", int'(ref_pulse), 0);
    r_div = 14'd300;
    wait_ref();
    count_ref(c);
    check("R3 ref ratio 300", c, 300);

    // R5 on reference side
    r_div = 14'd9;
    count_ref(c);
    check("R5 ref interval in progress", c, 300);
    count_ref(c);
    check("R5 ref new interval", c, 9);

    // R7: too small R ignored
    r_div = 14'd5;
    count_ref(c);
    check("R7 small R ignored 1", c, 9);
    count_ref(c);
    check("R7 small R ignored 2", c, 9);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule